// File: doc/BRIEF.md
# Bit-Set Control Register with Paged ROM Window

This block holds a 16-bit control word that software changes one bit at a time over a serial-style bit I/O bus. Each bus write carries a bit address and one data bit. The block masks the address down to four bits and then sets the addressed bit (data 1) or clears it (data 0). No other bit changes.

The stored word is decoded into named enables for the surrounding memory card. These are a ROM enable, a select that puts RAM in place of ROM on the two lowest ports, a banking inhibit (active-low in the register), a write enable, an LED drive, an alternate bank-mapper mode, a cartridge RAM overlay and a card enable. Six adjacent bits form a page number. That page number and a 13-bit offset inside an 8 KB window give the flat address into a paged ROM. The memories are outside this block. A read-back port returns the whole word.

Top module: `bitctl_top`

## Requirements
- R1: After reset, `ctrlWord` is 0x0000, `cardEnable`, `romEnable`, `gramSelect`, `writeEnable`, `ledOn`, `mapperAlt` and `ramOverlay` are 0, `bankInhibit` is 1, and `pageNum` is 0.
- R2: A clock edge with `bitWrEn` high makes bit n of `ctrlWord` equal to `bitData`, where n is the value of `busAddr[3:0]`. All other bits keep their values. The new word is visible right after that edge.
- R3: `busAddr[7:4]` have no effect. Two addresses that match in their low four bits reach the same register bit.
- R4: While `bitWrEn` is low, `ctrlWord` does not change, whatever `busAddr` and `bitData` carry.
- R5: `pageNum` equals `ctrlWord[8:3]`. `winAddr` equals `pageNum` * 0x2000 + `winOffset` and follows `winOffset` combinationally.
- R6: `cardEnable` is a separate output that a write to bit 9 loads on the same edge as the register bit, so it always equals `ctrlWord[9]`.
- R7: The decoded outputs are `romEnable` = bit 0, `gramSelect` = bit 1, `bankInhibit` = NOT bit 2, `writeEnable` = bit 10, `ledOn` = bit 12, `mapperAlt` = bit 14 and `ramOverlay` = bit 15. Bits 11 and 13 are stored and read back but drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitWrEn | input | 1 | Single-bit write strobe |
| busAddr | input | 8 | Bit address; only the low 4 bits are used |
| bitData | input | 1 | Value written to the addressed bit |
| winOffset | input | 13 | Byte offset inside the 8 KB ROM window |
| ctrlWord | output | 16 | Read-back of the whole control word |
| romEnable | output | 1 | ROM enable (bit 0) |
| gramSelect | output | 1 | RAM instead of ROM on ports 0 and 1 (bit 1) |
| bankInhibit | output | 1 | Banking inhibit, inverse of bit 2 |
| writeEnable | output | 1 | Write enable (bit 10) |
| ledOn | output | 1 | LED drive (bit 12) |
| mapperAlt | output | 1 | Alternate mapper mode (bit 14) |
| ramOverlay | output | 1 | Cartridge RAM overlay (bit 15) |
| cardEnable | output | 1 | Card enable, loaded by writes to bit 9 |
| pageNum | output | 6 | ROM window page (bits 8:3) |
| winAddr | output | 19 | Flat paged ROM address |

## Verification
A bit write takes effect on the clock edge that samples it. The read-back word, the decoded enables, `cardEnable` and `pageNum` are all due right after that one register stage. The bench drives inputs on the falling edge and compares every output on the next falling edge against a bench model. `winAddr` has no register in its path from `winOffset`, so the bench changes the offset while holding the register and checks the address after a short settle delay in the same cycle.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
  parameter int CTRL_W = 16;

  localparam int BIT_ROM    = 0;
  localparam int BIT_GRAM   = 1;
  localparam int BIT_BANKN  = 2;
  localparam int PAGE_LSB   = 3;
  localparam int BIT_CARD   = 9;
  localparam int BIT_WRITE  = 10;
  localparam int BIT_LED    = 12;
  localparam int BIT_MAPPER = 14;
  localparam int BIT_RAMOV  = 15;

  typedef struct packed {
    logic [CTRL_W-1:0] setMask;
    logic [CTRL_W-1:0] clrMask;
    logic              cardHit;
    logic              cardVal;
  } strobe_t;
endpackage

// File: rtl/bitctl_ctrl.sv
module bitctl_ctrl
  import bitctl_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitWrEn,
  input  logic [BUS_W-1:0] busAddr,
  input  logic             bitData,
  output strobe_t          stb
);
  localparam int IDX_W = $clog2(CTRL_W);

  logic [IDX_W-1:0] bitIdx;
  assign bitIdx = IDX_W'(busAddr);

  for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
    logic hit;
    assign hit = bitWrEn && (bitIdx == IDX_W'(i));
    assign stb.setMask[i] = hit && bitData;
    assign stb.clrMask[i] = hit && !bitData;
  end

  assign stb.cardHit = bitWrEn && (bitIdx == IDX_W'(BIT_CARD));
  assign stb.cardVal = bitData;

  // R2: a write touches at most one bit
  a_r2_one_bit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.setMask | stb.clrMask));
  // R4: no strobes without a write
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !bitWrEn |-> (stb.setMask == '0 && stb.clrMask == '0 && !stb.cardHit));
endmodule

// File: rtl/bitctl_dp.sv
module bitctl_dp
  import bitctl_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int OFF_W  = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [OFF_W-1:0]        winOffset,
  output logic [CTRL_W-1:0]       ctrlWord,
  output logic                    cardEnable,
  output logic [PAGE_W-1:0]       pageNum,
  output logic [PAGE_W+OFF_W-1:0] winAddr
);
  logic [CTRL_W-1:0] regQ;
  logic              cardQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ  <= '0;
      cardQ <= 1'b0;
    end else begin
      regQ <= (regQ & ~stb.clrMask) | stb.setMask;
      if (stb.cardHit) cardQ <= stb.cardVal;
    end
  end

  assign ctrlWord   = regQ;
  assign cardEnable = cardQ;
  assign pageNum    = regQ[PAGE_LSB +: PAGE_W];
  assign winAddr    = {pageNum, winOffset};

  // R2: set bits land
  a_r2_set: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask != '0) |=> ((regQ & $past(stb.setMask)) == $past(stb.setMask)));
  // R2: cleared bits land
  a_r2_clr: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask != '0) |=> ((regQ & $past(stb.clrMask)) == '0));
  // R2: untouched bits hold
  a_r2_others: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((regQ & ~$past(stb.setMask | stb.clrMask)) ==
              ($past(regQ) & ~$past(stb.setMask | stb.clrMask))));
  // R6: card enable tracks register bit
  a_r6_card_mirror: assert property (@(posedge clk) disable iff (!rstN)
    cardQ == regQ[BIT_CARD]);
endmodule

// File: rtl/bitctl_top.sv
module bitctl_top
  import bitctl_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int PAGE_W = 6,
  parameter int OFF_W  = 13,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitWrEn,
  input  logic [BUS_W-1:0]  busAddr,
  input  logic              bitData,
  input  logic [OFF_W-1:0]  winOffset,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              romEnable,
  output logic              gramSelect,
  output logic              bankInhibit,
  output logic              writeEnable,
  output logic              ledOn,
  output logic              mapperAlt,
  output logic              ramOverlay,
  output logic              cardEnable,
  output logic [PAGE_W-1:0] pageNum,
  output logic [ADDR_W-1:0] winAddr
);
  strobe_t stb;

  bitctl_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitWrEn(bitWrEn),
    .busAddr(busAddr), .bitData(bitData), .stb(stb)
  );

  bitctl_dp #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .winOffset(winOffset),
    .ctrlWord(ctrlWord), .cardEnable(cardEnable),
    .pageNum(pageNum), .winAddr(winAddr)
  );

  // R7 decode
  assign romEnable   = ctrlWord[BIT_ROM];
  assign gramSelect  = ctrlWord[BIT_GRAM];
  assign bankInhibit = ~ctrlWord[BIT_BANKN];
  assign writeEnable = ctrlWord[BIT_WRITE];
  assign ledOn       = ctrlWord[BIT_LED];
  assign mapperAlt   = ctrlWord[BIT_MAPPER];
  assign ramOverlay  = ctrlWord[BIT_RAMOV];
endmodule

// File: tb/tb_bitctl_top.sv
module tb_bitctl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        bitData = 1'b0;
  logic [12:0] winOffset = '0;
  logic [15:0] ctrlWord;
  logic        romEnable, gramSelect, bankInhibit, writeEnable;
  logic        ledOn, mapperAlt, ramOverlay, cardEnable;
  logic [5:0]  pageNum;
  logic [18:0] winAddr;

  int checks = 0;
  int errors = 0;
  logic [15:0] model = '0;

  bitctl_top dut (.*);

  always #2.5 clk = ~clk;

  function automatic logic [18:0] expAddr(logic [15:0] w, logic [12:0] off);
    return 19'(w[8:3]) * 19'h2000 + 19'(off);
  endfunction

  function automatic logic [7:0] expDecode(logic [15:0] w);
    return {w[0], w[1], ~w[2], w[10], w[12], w[14], w[15], w[9]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk({tag, " R2 word"}, 32'(ctrlWord), 32'(model));
    chk({tag, " R7/R6 decode"},
        32'({romEnable, gramSelect, bankInhibit, writeEnable, ledOn,
             mapperAlt, ramOverlay, cardEnable}), 32'(expDecode(model)));
    chk({tag, " R6 card"}, 32'(cardEnable), 32'(model[9]));
    chk({tag, " R5 page"}, 32'(pageNum), 32'(model[8:3]));
    chk({tag, " R5 addr"}, 32'(winAddr), 32'(expAddr(model, winOffset)));
  endtask

  task automatic doWrite(logic [7:0] a, logic d, logic en);
    bitWrEn = en; busAddr = a; bitData = d;
    @(negedge clk);
    if (en) model[a[3:0]] = d;
    bitWrEn = 1'b0; busAddr = $urandom; bitData = $urandom;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    checkAll("R1 in-reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after-reset");
    chk("R1 bankInhibit", 32'(bankInhibit), 32'd1);

    for (int i = 0; i < 16; i++) begin
      doWrite(8'(i), 1'b1, 1'b1);
      checkAll("R2 walk-set");
    end
    for (int i = 0; i < 16; i++) begin
      doWrite(8'(i) | 8'hA0, 1'b0, 1'b1);
      checkAll("R3 walk-clear high-bits");
    end

    doWrite(8'hF9, 1'b1, 1'b1);
    checkAll("R3 R6 card via alias");
    chk("R6 card set", 32'(cardEnable), 32'd1);
    doWrite(8'h09, 1'b0, 1'b1);
    chk("R6 card clear", 32'(cardEnable), 32'd0);

    doWrite(8'h0B, 1'b1, 1'b1);
    doWrite(8'h0D, 1'b1, 1'b1);
    checkAll("R7 bits 11 13 stored");
    chk("R7 bit13 no output", 32'({romEnable, gramSelect, writeEnable, ledOn,
        mapperAlt, ramOverlay, cardEnable, bankInhibit}), 32'h01);

    for (int i = 3; i <= 8; i++) doWrite(8'(i), 1'b1, 1'b1);
    winOffset = 13'h1FFF; #1;
    chk("R5 top page max offset", 32'(winAddr), 32'h7FFFF);
    winOffset = 13'h0000; #1;
    chk("R5 top page zero offset", 32'(winAddr), 32'h7E000);
    @(negedge clk);

    for (int i = 0; i < 20; i++) begin
      doWrite(8'($urandom), 1'($urandom), 1'b0);
      checkAll("R4 no-write");
    end

    for (int i = 0; i < 400; i++) begin
      doWrite(8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0));
      winOffset = 13'($urandom);
      #1;
      checkAll("R2 random");
    end

    rstN = 1'b0; #1;
    model = '0;
    checkAll("R1 re-reset");
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    checkAll("R1 post re-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule